// File: doc/BRIEF.md
# Serial Quad Wiper Register Port

This block is the serial control port for four 8-bit wiper setting registers. A host raises chip select and clocks in a frame on the serial data input: a start bit of 1, two address bits (low address bit first), then eight data bits, least significant bit first. The input is sampled on the rising clock edge. Once the address is known, the port shifts the addressed register's old value out on the serial output, least significant bit first, while the new value shifts in. Every transfer is therefore a read and a write at the same time.

Each wiper register has a shadow non-volatile copy, modelled here as a plain register. A `store` input held high at the commit edge writes the new value into the shadow copy as well. If chip select drops before the commit edge, the frame is aborted. The addressed register then takes its shadow value instead of the new data. This lets a host poll a setting without changing it, provided that setting was stored. The serial output has an enable that follows chip select, so several ports can share one return line.

Top module: `wpr_serial_port`

## Requirements
- R1: After reset, every wiper register and every shadow copy holds 8'h80, and `sdo_oe` is 0.
- R2: A full frame writes the value D0..D7 (D0 sent first, D0 is bit 0) into the register selected by address {A1,A0} (A0 sent first). The other three registers do not change.
- R3: During the eight data-bit clocks, `sdo` shows the addressed register's previous value, bit 0 first. Outside the data bits, `sdo` is 0.
- R4: `sdo_oe` is 1 exactly while `cs` is 1.
- R5: Counting the start-bit edge as edge 1, D7 is sampled on edge 11. The wiper changes on edge 12, and not earlier.
- R6: If `cs` stays high after a full frame, a start bit can be sampled on edge 13, the second edge after D7.
- R7: If `cs` is low at any edge after the address is complete, up to and including edge 12, the addressed register is reloaded from its shadow copy. The other registers do not change.
- R8: If `cs` drops before the address is complete, no register changes.
- R9: While the port is idle with `cs` high, 0 bits on `sdi` are ignored until a 1 arrives, and that 1 begins a frame.
- R10: If `store` is 1 at edge 12 of a full frame, the shadow copy also takes the new value. Otherwise the shadow copies keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; input is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select; a frame is active while high |
| sdi | input | 1 | Serial data input |
| store | input | 1 | Copy the committed value into the shadow copy |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for sdo (high impedance when 0) |
| wiper | output | 32 | Wiper registers, register n in bits [8n+7:8n] |

## Verification
The assertions check, on every cycle, that:
- the wiper and shadow values change only on a commit or abort event;
- an abort leaves the addressed register equal to its shadow value;
- the frame events never overlap, and the address phase always leads into data or an abort;
- the serial output stays quiet outside the data bits.

Only the bench scenarios can show that the returned bits match the old value in order. They also show that the new value lands on the correct edge, that back-to-back frames work, and that aborts at the address boundary and at the commit edge behave as required.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  typedef enum logic [1:0] {
    WS_IDLE   = 2'd0,
    WS_ADDR   = 2'd1,
    WS_DATA   = 2'd2,
    WS_COMMIT = 2'd3
  } wpr_state_e;

  // Edge number (start bit = 1) on which the new value is committed.
  function automatic int commit_edge(input int addr_bits, input int data_bits);
    return 1 + addr_bits + data_bits + 1;
  endfunction
endpackage

// File: rtl/wpr_frame_ctrl.sv
module wpr_frame_ctrl
  import wpr_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sdi,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] load_addr,
  output logic              load_ev,
  output logic              shift_ev,
  output logic              commit_ev,
  output logic              abort_ev,
  output logic              data_phase
);
  localparam int MAXC  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAXC) + 1;

  wpr_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;

  // Address arrives low bit first: shift in at the top.
  function automatic logic [ADDR_W-1:0] addr_shift(input logic [ADDR_W-1:0] cur,
                                                   input logic b);
    logic [ADDR_W-1:0] r;
    r = cur >> 1;
    r[ADDR_W-1] = b;
    return r;
  endfunction

  logic last_addr_bit;
  logic last_data_bit;
  assign last_addr_bit = (cnt == CNT_W'(ADDR_W - 1));
  assign last_data_bit = (cnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= WS_IDLE;
      cnt    <= '0;
      addr_q <= '0;
    end else begin
      case (state)
        WS_IDLE: begin
          if (cs && sdi) begin
            state <= WS_ADDR;
            cnt   <= '0;
          end
        end
        WS_ADDR: begin
          if (!cs) begin
            state <= WS_IDLE;
          end else begin
            addr_q <= addr_shift(addr_q, sdi);
            if (last_addr_bit) begin
              state <= WS_DATA;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        WS_DATA: begin
          if (!cs) begin
            state <= WS_IDLE;
          end else if (last_data_bit) begin
            state <= WS_COMMIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  assign addr       = addr_q;
  assign load_addr  = addr_shift(addr_q, sdi);
  assign load_ev    = (state == WS_ADDR) && cs && last_addr_bit;
  assign data_phase = (state == WS_DATA);
  assign shift_ev   = data_phase && cs;
  assign commit_ev  = (state == WS_COMMIT) && cs;
  assign abort_ev   = ((state == WS_DATA) || (state == WS_COMMIT)) && !cs;
endmodule

// File: rtl/wpr_shifter.sv
module wpr_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              load_ev,
  input  logic              shift_ev,
  input  logic              data_phase,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] shreg,
  output logic              sdo_bit
);
  // Data arrives LSB first: new bit enters at the top, old bit leaves at bit 0.
  function automatic logic [DATA_W-1:0] lsb_shift(input logic [DATA_W-1:0] cur,
                                                  input logic b);
    logic [DATA_W-1:0] r;
    r = cur >> 1;
    r[DATA_W-1] = b;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (load_ev) begin
      shreg <= rd_data;
    end else if (shift_ev) begin
      shreg <= lsb_shift(shreg, sdi);
    end
  end

  assign sdo_bit = data_phase & shreg[0];
endmodule

// File: rtl/wpr_bank.sv
module wpr_bank #(
  parameter int          NREG      = 4,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  RESET_VAL = 8'h80,
  localparam int         ADDR_W    = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [ADDR_W-1:0]        load_addr,
  input  logic                     commit_ev,
  input  logic                     abort_ev,
  input  logic                     store,
  input  logic [DATA_W-1:0]        new_data,
  output logic [DATA_W-1:0]        rd_data,
  output logic [NREG*DATA_W-1:0]   wiper_flat,
  output logic [NREG*DATA_W-1:0]   nv_flat
);
  logic [DATA_W-1:0] wip [NREG];
  logic [DATA_W-1:0] nv  [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic hit;
    assign hit = (addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wip[g] <= DATA_W'(RESET_VAL);
        nv[g]  <= DATA_W'(RESET_VAL);
      end else if (hit && commit_ev) begin
        wip[g] <= new_data;
        if (store) nv[g] <= new_data;
      end else if (hit && abort_ev) begin
        wip[g] <= nv[g];
      end
    end

    assign wiper_flat[g*DATA_W +: DATA_W] = wip[g];
    assign nv_flat[g*DATA_W +: DATA_W]    = nv[g];
  end

  assign rd_data = wip[load_addr];
endmodule

// File: rtl/wpr_serial_port.sv
module wpr_serial_port #(
  parameter int         NREG      = 4,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] RESET_VAL = 8'h80
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs,
  input  logic                   sdi,
  input  logic                   store,
  output logic                   sdo,
  output logic                   sdo_oe,
  output logic [NREG*DATA_W-1:0] wiper
);
  localparam int ADDR_W = $clog2(NREG);

  logic [ADDR_W-1:0]      addr;
  logic [ADDR_W-1:0]      load_addr;
  logic                   load_ev;
  logic                   shift_ev;
  logic                   commit_ev;
  logic                   abort_ev;
  logic                   data_phase;
  logic [DATA_W-1:0]      rd_data;
  logic [DATA_W-1:0]      shreg;
  logic                   sdo_bit;
  logic [NREG*DATA_W-1:0] nv_flat;

  wpr_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sdi(sdi),
    .addr(addr), .load_addr(load_addr), .load_ev(load_ev),
    .shift_ev(shift_ev), .commit_ev(commit_ev), .abort_ev(abort_ev),
    .data_phase(data_phase)
  );

  wpr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .load_ev(load_ev),
    .shift_ev(shift_ev), .data_phase(data_phase), .rd_data(rd_data),
    .shreg(shreg), .sdo_bit(sdo_bit)
  );

  wpr_bank #(.NREG(NREG), .DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) u_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .load_addr(load_addr),
    .commit_ev(commit_ev), .abort_ev(abort_ev), .store(store),
    .new_data(shreg), .rd_data(rd_data), .wiper_flat(wiper), .nv_flat(nv_flat)
  );

  assign sdo    = sdo_bit;
  assign sdo_oe = cs;
endmodule

// File: rtl/wpr_serial_port_chk.sv
module wpr_serial_port_chk #(
  parameter int NREG   = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(NREG)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs,
  input logic                   store,
  input logic                   sdo,
  input logic                   sdo_oe,
  input logic [NREG*DATA_W-1:0] wiper,
  input logic [NREG*DATA_W-1:0] nv_flat,
  input logic [ADDR_W-1:0]      addr,
  input logic                   load_ev,
  input logic                   shift_ev,
  input logic                   commit_ev,
  input logic                   abort_ev,
  input logic                   data_phase
);
  function automatic logic [DATA_W-1:0] slot(input logic [NREG*DATA_W-1:0] bus,
                                             input logic [ADDR_W-1:0] i);
    return bus[int'(i)*DATA_W +: DATA_W];
  endfunction

  a_r5_wiper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_ev || abort_ev) |=> $stable(wiper));

  a_r10_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_ev && store) |=> $stable(nv_flat));

  a_r7_abort_reload: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> slot(wiper, $past(addr)) == slot(nv_flat, $past(addr)));

  a_r3_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !data_phase |-> !sdo);

  a_r4_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !sdo_oe);

  a_r6_events_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_ev, shift_ev, commit_ev, abort_ev}));

  a_r8_addr_leads_data: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (shift_ev || abort_ev));
endmodule

bind wpr_serial_port wpr_serial_port_chk #(.NREG(NREG), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .store(store), .sdo(sdo), .sdo_oe(sdo_oe),
  .wiper(wiper), .nv_flat(nv_flat), .addr(addr), .load_ev(load_ev),
  .shift_ev(shift_ev), .commit_ev(commit_ev), .abort_ev(abort_ev),
  .data_phase(data_phase)
);

// File: tb/test_wpr_serial_port.sv
`timescale 1ns/1ps
module test_wpr_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sdi = 1'b0;
  logic store = 1'b0;
  logic sdo;
  logic sdo_oe;
  logic [31:0] wiper;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_wip [4];
  logic [7:0] m_nv  [4];

  always #4 clk = ~clk;

  wpr_serial_port i_wpr_serial_port (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sdi(sdi), .store(store),
    .sdo(sdo), .sdo_oe(sdo_oe), .wiper(wiper)
  );

  // {addr[1:0], store, data[7:0]}
  localparam logic [10:0] VEC [6] = '{
    {2'd0, 1'b0, 8'h5A},
    {2'd3, 1'b1, 8'hC3},
    {2'd1, 1'b0, 8'h01},
    {2'd0, 1'b1, 8'hFF},
    {2'd2, 1'b1, 8'h00},
    {2'd3, 1'b0, 8'h7E}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_bus();
    return {m_wip[3], m_wip[2], m_wip[1], m_wip[0]};
  endfunction

  // hi_edges: edges sampled with cs high (12 = full frame). Edge 1 = start.
  task automatic run_frame(input logic [1:0] a, input logic [7:0] d, input logic st,
                           input int hi_edges, input bit keep_cs,
                           output logic [7:0] rd, output logic [31:0] pre);
    rd  = '0;
    pre = '0;
    for (int e = 1; e <= hi_edges; e++) begin
      @(negedge clk);
      cs    = 1'b1;
      store = st;
      if (e == 1)      sdi = 1'b1;
      else if (e == 2) sdi = a[0];
      else if (e == 3) sdi = a[1];
      else if (e <= 11) begin
        sdi = d[e-4];
        #1 rd[e-4] = sdo;
      end else begin
        sdi = 1'b0;
        #1 pre = wiper;
      end
    end
    if (!keep_cs) begin
      @(negedge clk);
      cs = 1'b0; sdi = 1'b0; store = 1'b0;
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rd;
    logic [31:0] pre;
    for (int i = 0; i < 4; i++) begin m_wip[i] = 8'h80; m_nv[i] = 8'h80; end

    repeat (3) @(negedge clk);
    #1;
    check("R1", "reset wipers", wiper, 32'h80808080);
    check("R1", "reset sdo_oe", {31'd0, sdo_oe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R4", "oe low with cs low", {31'd0, sdo_oe}, 32'd0);

    // Shadow reset value: write reg0 without store, then abort -> 80.
    run_frame(2'd0, 8'h44, 1'b0, 12, 0, rd, pre);
    check("R2", "write reg0 44", wiper, 32'h80808044);
    run_frame(2'd0, 8'h99, 1'b0, 6, 0, rd, pre);
    check("R1", "shadow reset value via abort", wiper, 32'h80808080);

    // Vector table walk.
    for (int v = 0; v < 6; v++) begin
      logic [1:0] a;
      logic       st;
      logic [7:0] d;
      {a, st, d} = VEC[v];
      run_frame(a, d, st, 12, 0, rd, pre);
      check("R3", $sformatf("vec%0d readout", v), {24'd0, rd}, {24'd0, m_wip[a]});
      check("R5", $sformatf("vec%0d before commit", v), pre, model_bus());
      m_wip[a] = d;
      if (st) m_nv[a] = d;
      check("R2", $sformatf("vec%0d after commit", v), wiper, model_bus());
    end

    // R7: abort mid-data on reg1 (shadow 80) and reg3 (shadow C3, stored R10).
    run_frame(2'd1, 8'hEE, 1'b0, 7, 0, rd, pre);
    m_wip[1] = m_nv[1];
    check("R7", "abort mid-data reg1", wiper, model_bus());
    run_frame(2'd3, 8'h12, 1'b0, 4, 0, rd, pre);
    m_wip[3] = m_nv[3];
    check("R10", "stored shadow reg3 restored", {24'd0, wiper[31:24]}, 32'h000000C3);

    // R7 boundary: cs low exactly on commit edge (edge 12).
    run_frame(2'd2, 8'hAA, 1'b0, 12, 0, rd, pre);
    m_wip[2] = 8'hAA;
    check("R2", "write reg2 AA", wiper, model_bus());
    run_frame(2'd2, 8'h55, 1'b1, 11, 0, rd, pre);
    m_wip[2] = m_nv[2];
    check("R7", "abort at commit edge reg2", wiper, model_bus());
    run_frame(2'd1, 8'h00, 1'b1, 12, 0, rd, pre);
    m_wip[1] = 8'h00; m_nv[1] = 8'h00;
    run_frame(2'd1, 8'h33, 1'b0, 5, 0, rd, pre);
    check("R10", "store frame updated shadow reg1", wiper, model_bus());

    // R8: cs drops inside the address.
    run_frame(2'd2, 8'h77, 1'b0, 2, 0, rd, pre);
    check("R8", "abort in address (2 edges)", wiper, model_bus());
    run_frame(2'd1, 8'h77, 1'b0, 1, 0, rd, pre);
    check("R8", "abort after start bit", wiper, model_bus());

    // R9/R4: idle zeros with cs high.
    @(negedge clk);
    cs = 1'b1; sdi = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    check("R4", "oe high with cs high", {31'd0, sdo_oe}, 32'd1);
    check("R3", "sdo quiet while idle", {31'd0, sdo}, 32'd0);
    check("R9", "zeros change nothing", wiper, model_bus());
    run_frame(2'd3, 8'hB4, 1'b0, 12, 0, rd, pre);
    check("R9", "frame after zeros readout", {24'd0, rd}, {24'd0, m_wip[3]});
    m_wip[3] = 8'hB4;
    check("R9", "frame after zeros write", wiper, model_bus());

    // R6: back-to-back frames with cs held high.
    run_frame(2'd0, 8'h11, 1'b0, 12, 1, rd, pre);
    run_frame(2'd0, 8'h22, 1'b0, 12, 0, rd, pre);
    check("R6", "second frame reads first value", {24'd0, rd}, 32'h00000011);
    m_wip[0] = 8'h22;
    check("R6", "second frame committed", wiper, model_bus());

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule